// File: doc/BRIEF.md
# Snoop Control Register File

This block is the software-visible register window of a snoop control unit serving a small multiprocessor cluster. It sits on a simple register bus and decodes a 256-byte window. It holds a one-bit enable and a read-only word that describes the cluster, and computes that word from the processor count. It also holds a 32-bit power status word with one byte per processor. Software can write that word in byte, halfword or word units at any byte within it.

The block models only the programming interface. The command, filter and access-control registers that the snooping hardware would own read as zero, and writes to them change nothing. Read data is registered and appears on the cycle after the read enable.

Top module: `snoop_ctl_regs`

## Requirements
- R1: After reset the enable bit reads as 0, so a read at offset 0x00 returns 0.
- R2: A write at offset 0x00 stores bit 0 of the write data and discards the other bits. A read at offset 0x00 returns the stored bit in bit 0, with all other bits zero.
- R3: Offset 0x04 is read-only. It returns (NCPU-1) in bits [1:0] and a mask of NCPU ones starting at bit 4. Writes to it have no effect.
- R4: A read at offset 0x08+k, for k from 0 to 3, returns the power status word shifted right by 8*k bits, with zero fill.
- R5: A write at offset 0x08+k with size code 1, 2 or 4 bytes builds a mask of 0xFF, 0xFFFF or 0xFFFFFFFF and shifts it left by 8*k. The bits under the shifted mask take the write data shifted left by 8*k. All other bits keep their value. Bits shifted past bit 31 are dropped.
- R6: A write whose size field is anything other than 1, 2 or 4 changes no state.
- R7: Offsets 0x0C, 0x40, 0x44, 0x50 and 0x54, and every offset the block does not decode, read as zero. Writes to them change no stored state.
- R8: Read data is valid on the cycle after the cycle in which the read enable is sampled.
- R9: Reset leaves the power status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Byte offset within the window |
| wdata | input | 32 | Write data, right-aligned |
| size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with NCPU set to 3. This makes the configuration word non-trivial, 0x72, so the count field and the mask field are both visible at once. The bench keeps a model of the power status word and sweeps every byte offset 0x08 to 0x0B against every size code from 0 to 7. This reaches the writes that spill past bit 31 and the discarded sizes. It also reads back every offset in the 256-byte window to check the zero-read regions, and it checks that the power word survives a reset.

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs #(
  parameter int NCPU = 1,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [2:0]    size,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] OFF_CTL = 8'h00;
  localparam logic [AW-1:0] OFF_CFG = 8'h04;
  localparam logic [AW-1:0] OFF_PWR = 8'h08;
  localparam logic [DW-1:0] CFG_VAL =
    DW'((((1 << NCPU) - 1) << 4) | (NCPU - 1));

  initial assert (NCPU >= 1 && NCPU <= 4);

  logic          en_q;
  logic [DW-1:0] pwr_q;
  logic [DW-1:0] mask, wmask, wshift;
  logic          pwr_hit;
  logic [4:0]    sh;
  logic          size_ok;
  logic [DW-1:0] rd_next;

  assign pwr_hit = addr[AW-1:2] == OFF_PWR[AW-1:2];
  assign sh      = {addr[1:0], 3'b000};

  always_comb begin
    size_ok = 1'b1;
    case (size)
      3'd1:    mask = 32'h0000_00ff;
      3'd2:    mask = 32'h0000_ffff;
      3'd4:    mask = 32'hffff_ffff;
      default: begin mask = '0; size_ok = 1'b0; end
    endcase
  end

  assign wmask  = mask << sh;
  assign wshift = (wdata & mask) << sh;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else if (wr_en && size_ok && addr == OFF_CTL) en_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (wr_en && size_ok && pwr_hit)
      pwr_q <= (pwr_q & ~wmask) | wshift;
  end

  always_comb begin
    rd_next = '0;
    if (addr == OFF_CTL) rd_next = {{(DW-1){1'b0}}, en_q};
    else if (addr == OFF_CFG) rd_next = CFG_VAL;
    else if (pwr_hit) rd_next = pwr_q >> sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  a_r1_reset_clears_en: assert property (@(posedge clk)
    !rst_n |=> !en_q);
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size_ok && addr == OFF_CTL) |=> en_q == $past(wdata[0]));
  a_r6_bad_size_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !size_ok) |=> ($stable(pwr_q) && $stable(en_q)));
  a_r7_zero_region: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[AW-1:4] != '0) |=> rdata == '0);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && $past(rst_n)) |=> $stable(rdata));
  a_r2_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_CTL) |=> rdata[DW-1:1] == '0);
endmodule

// File: tb/test_snoop_ctl_regs.sv
module test_snoop_ctl_regs;
  localparam int NCPU = 3;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [2:0] size = 0;
  logic [31:0] rdata;
  int tests = 0, fails = 0;
  logic [31:0] model;

  always #4 clk = ~clk;

  snoop_ctl_regs #(.NCPU(NCPU)) i_snoop_ctl_regs (.*);

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s);
    @(negedge clk); addr = a; wdata = d; size = s; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r, msk, cfg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(8'h00, r); chk("R1", r, 0);
    // R2
    wr(8'h00, 32'hffff_fffe, 3'd4); rd(8'h00, r); chk("R2", r, 0);
    wr(8'h00, 32'h8000_0003, 3'd4); rd(8'h00, r); chk("R2", r, 1);
    // R3
    cfg = (((1 << NCPU) - 1) << 4) | (NCPU - 1);
    rd(8'h04, r); chk("R3", r, cfg);
    wr(8'h04, 32'hffff_ffff, 3'd4); rd(8'h04, r); chk("R3", r, cfg);
    // R5 / R6 / R4 sweep
    wr(8'h08, 32'h0, 3'd4); model = 0;
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 8; s++) begin
        logic [31:0] d;
        d = 32'h9e37_79b9 * (k * 8 + s + 1);
        wr(8'h08 + 8'(k), d, 3'(s));
        if (s == 1 || s == 2 || s == 4) begin
          msk = (s == 1) ? 32'hff : (s == 2) ? 32'hffff : 32'hffff_ffff;
          model = (model & ~(msk << (8*k))) | ((d & msk) << (8*k));
        end
        rd(8'h08, r); chk((s == 1 || s == 2 || s == 4) ? "R5" : "R6", r, model);
        for (int j = 1; j < 4; j++) begin
          rd(8'h08 + 8'(j), r); chk("R4", r, model >> (8*j));
        end
      end
    // R7 writes and full window sweep
    wr(8'h0c, 32'hffff_ffff, 3'd4); wr(8'h40, 32'h1234, 3'd4);
    wr(8'h54, 32'h1, 3'd4); wr(8'h01, 32'h0, 3'd1);
    for (int a = 0; a < 256; a++) begin
      logic [31:0] e;
      rd(8'(a), r);
      if (a == 0) e = 1;
      else if (a == 4) e = cfg;
      else if (a >= 8 && a <= 11) e = model >> (8*(a-8));
      else e = 0;
      chk("R7", r, e);
    end
    // R8: data appears one cycle after rd_en
    @(negedge clk); addr = 8'h04; rd_en = 1;
    @(negedge clk); rd_en = 0; addr = 8'h00;
    chk("R8", rdata, cfg);
    @(negedge clk); chk("R8", rdata, cfg);
    // R9 and R1
    wr(8'h08, 32'ha5c3_1e0f, 3'd4); model = 32'ha5c3_1e0f;
    @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    rd(8'h08, r); chk("R9", r, model);
    rd(8'h00, r); chk("R1", r, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule